// File: doc/BRIEF.md
# GPIO Port Controller

This block is a parameterised general-purpose I/O port that sits behind a small memory-mapped register bus. Software drives the pins through an output latch. The latch can be loaded whole through the data register. It can also be changed bit by bit through a write-one-to-set register and a write-one-to-clear register. Either of these lets one agent change some pins without a read-modify-write race against another agent. A read of the data register returns the pin levels after they pass through a two-flop synchroniser. A read of the set register returns the latch itself.

The direction scheme is fixed at build time and takes one of three forms:

- An output-direction register, where a 1 makes the pin an output.
- An input-direction register, where a 1 makes the pin an input.
- No direction register at all. Every pin is then driven and read back at the same time.

A second build option reverses the mapping between pins and register bits. The output side presents a value and an enable for every pin. The input side takes the raw pad levels.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset the output latch is all zeros and every pin is an input. In output-direction mode the direction register reads zero and every enable is 0. In input-direction mode the direction register reads all ones and every enable is 0.
- R2: A write to byte offset 0x00 loads the whole output latch from the write data. The latch appears on `pin_out` right after the accepting edge.
- R3: A write to offset 0x04 sets to 1 every latch bit written as 1 and leaves every bit written as 0 unchanged.
- R4: A write to offset 0x08 clears to 0 every latch bit written as 1 and leaves every bit written as 0 unchanged.
- R5: A read of offset 0x04 returns the output latch, not the pin levels. A read of offset 0x08 returns zero.
- R6: A read of offset 0x00 returns the synchronised pin levels. A change on `pin_in` is first seen by a read accepted at the third rising edge after the change. Reads accepted at the first and second edges still return the old level.
- R7: In output-direction mode (`DIR_MODE`=1), a 1 at a bit of the direction register at offset 0x0C sets that pin's enable to 1. A 0 there sets the enable to 0. The register reads back as written.
- R8: In input-direction mode (`DIR_MODE`=2), the polarity is inverted. A 1 at a bit of the direction register sets that pin's enable to 0, and a 0 sets it to 1.
- R9: In bidirectional mode (`DIR_MODE`=0), every enable is 1 at all times. Writes to offset 0x0C are ignored, and reads of 0x0C return zero.
- R10: With `REVERSE`=1, pin n is carried on register bit W-1-n in every register and on the data read. With `REVERSE`=0, pin n is carried on register bit n.
- R11: A read of any offset other than 0x00, 0x04, 0x08 and 0x0C returns zero. A write to such an offset changes neither the latch nor the direction register.
- R12: Read data appears on `bus_rdata` after the edge that accepts the read, and it holds until the next read is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | W | Write data, in register bit order |
| bus_rdata | output | W | Registered read data |
| pin_in | input | W | Raw pad levels, in pin order |
| pin_out | output | W | Output value per pin |
| pin_oe | output | W | Output enable per pin, 1 = drive |

## Verification
The bench runs three builds side by side:

- 32-bit, output-direction mode, normal order.
- 16-bit, input-direction mode, reversed order.
- 8-bit, bidirectional mode, reversed order.

With these three, a design that ignores the reversal or the inverted polarity misplaces pins on at least one of them.

Directed cases cover the following:

- A set or clear write with zero bits. A design that treats the write as a plain load would wipe the untouched bits.
- A read of the set register while the pins differ from the latch. A design that returns pin levels there is caught.
- The exact synchroniser latency. One flop too few or too many shows up as a read that is one cycle early or one cycle late.
- A write to an unused offset. A design with a loose decode would let it alias onto a real register.

Random mixes of all operations are checked against bench models after every access.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int DIRM_BIDIR  = 0;
    localparam int DIRM_OUTPUT = 1;
    localparam int DIRM_INPUT  = 2;

    localparam int OFF_DATA = 'h0;
    localparam int OFF_SET  = 'h4;
    localparam int OFF_CLR  = 'h8;
    localparam int OFF_DIR  = 'hC;

    typedef enum logic [2:0] {
        REG_DATA,
        REG_SET,
        REG_CLR,
        REG_DIR,
        REG_NONE
    } reg_sel_e;

    // Pin/register reorder on the low w bits; its own inverse.
    function automatic logic [63:0] bit_reorder(logic [63:0] v, int w, bit rev);
        logic [63:0] r;
        r = '0;
        for (int i = 0; i < 64; i++) begin
            if (i < w) r[i] = rev ? v[w - 1 - i] : v[i];
        end
        return r;
    endfunction

endpackage

// File: rtl/gpio_bit_order.sv
module gpio_bit_order #(
    parameter int W       = 32,
    parameter bit REVERSE = 1'b0
) (
    input  logic [W-1:0] a,
    output logic [W-1:0] y
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (REVERSE) begin : g_rev
            assign y[i] = a[W-1-i];
        end else begin : g_fwd
            assign y[i] = a[i];
        end
    end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            q        <= '0;
        end else begin
            stage1_q <= d;
            q        <= stage1_q;
        end
    end
endmodule

// File: rtl/gpio_out_regs.sv
module gpio_out_regs
    import gpio_port_pkg::*;
#(
    parameter int W        = 32,
    parameter int DIR_MODE = DIRM_OUTPUT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_data,
    input  logic         wr_set,
    input  logic         wr_clr,
    input  logic         wr_dir,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] latch_q,
    output logic [W-1:0] dir_q
);
    localparam logic [W-1:0] DIR_RST = (DIR_MODE == DIRM_INPUT) ? {W{1'b1}} : {W{1'b0}};

    logic [W-1:0] set_m;
    logic [W-1:0] clr_m;

    assign set_m = wr_set ? wdata : '0;
    assign clr_m = wr_clr ? wdata : '0;

    // Clear is applied after set, so it wins on a shared bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else if (wr_data) begin
            latch_q <= wdata;
        end else begin
            latch_q <= (latch_q | set_m) & ~clr_m;
        end
    end

    if (DIR_MODE == DIRM_BIDIR) begin : g_no_dir
        assign dir_q = '0;
    end else begin : g_dir
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dir_q <= DIR_RST;
            end else if (wr_dir) begin
                dir_q <= wdata;
            end
        end
    end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int W        = 32,
    parameter int DIR_MODE = DIRM_OUTPUT,
    parameter bit REVERSE  = 1'b0,
    parameter int ADDR_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      pin_in,
    output logic [W-1:0]      pin_out,
    output logic [W-1:0]      pin_oe
);
    reg_sel_e     reg_sel;
    logic         acc_wr;
    logic         acc_rd;
    logic [W-1:0] latch_q;
    logic [W-1:0] dir_q;
    logic [W-1:0] drive_en;
    logic [W-1:0] pins_sync;
    logic [W-1:0] pins_reg;
    logic [W-1:0] rd_mux;

    assign acc_wr = bus_sel & bus_wr;
    assign acc_rd = bus_sel & ~bus_wr;

    always_comb begin
        if (bus_addr == ADDR_W'(OFF_DATA))      reg_sel = REG_DATA;
        else if (bus_addr == ADDR_W'(OFF_SET))  reg_sel = REG_SET;
        else if (bus_addr == ADDR_W'(OFF_CLR))  reg_sel = REG_CLR;
        else if (bus_addr == ADDR_W'(OFF_DIR))  reg_sel = REG_DIR;
        else                                    reg_sel = REG_NONE;
    end

    gpio_out_regs #(.W(W), .DIR_MODE(DIR_MODE)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_data (acc_wr && reg_sel == REG_DATA),
        .wr_set  (acc_wr && reg_sel == REG_SET),
        .wr_clr  (acc_wr && reg_sel == REG_CLR),
        .wr_dir  (acc_wr && reg_sel == REG_DIR),
        .wdata   (bus_wdata),
        .latch_q (latch_q),
        .dir_q   (dir_q)
    );

    if (DIR_MODE == DIRM_INPUT) begin : g_en_inv
        assign drive_en = ~dir_q;
    end else if (DIR_MODE == DIRM_OUTPUT) begin : g_en_fwd
        assign drive_en = dir_q;
    end else begin : g_en_all
        assign drive_en = '1;
    end

    gpio_bit_order #(.W(W), .REVERSE(REVERSE)) u_ord_out (.a(latch_q),   .y(pin_out));
    gpio_bit_order #(.W(W), .REVERSE(REVERSE)) u_ord_oe  (.a(drive_en),  .y(pin_oe));

    gpio_in_sync #(.W(W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pins_sync)
    );

    gpio_bit_order #(.W(W), .REVERSE(REVERSE)) u_ord_in  (.a(pins_sync), .y(pins_reg));

    always_comb begin
        unique case (reg_sel)
            REG_DATA: rd_mux = pins_reg;
            REG_SET:  rd_mux = latch_q;
            REG_CLR:  rd_mux = '0;
            REG_DIR:  rd_mux = dir_q;
            REG_NONE: rd_mux = '0;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (acc_rd) begin
            bus_rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk
    import gpio_port_pkg::*;
#(
    parameter int W        = 32,
    parameter int DIR_MODE = DIRM_OUTPUT,
    parameter bit REVERSE  = 1'b0,
    parameter int ADDR_W   = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [W-1:0]      bus_wdata,
    input logic [W-1:0]      bus_rdata,
    input logic [W-1:0]      pin_out,
    input logic [W-1:0]      pin_oe
);
    logic [W-1:0] out_reg;
    logic         unused_off;

    assign out_reg    = W'(bit_reorder(64'(pin_out), W, REVERSE));
    assign unused_off = bus_addr != ADDR_W'(OFF_DATA) && bus_addr != ADDR_W'(OFF_SET) &&
                        bus_addr != ADDR_W'(OFF_CLR)  && bus_addr != ADDR_W'(OFF_DIR);

    assert_data_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == ADDR_W'(OFF_DATA)) |=> out_reg == $past(bus_wdata));

    assert_set_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == ADDR_W'(OFF_SET)) |=>
            ((out_reg & $past(bus_wdata)) == $past(bus_wdata)) &&
            ((out_reg & ~$past(bus_wdata)) == ($past(out_reg) & ~$past(bus_wdata))));

    assert_clear_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == ADDR_W'(OFF_CLR)) |=>
            ((out_reg & $past(bus_wdata)) == '0) &&
            ((out_reg & ~$past(bus_wdata)) == ($past(out_reg) & ~$past(bus_wdata))));

    assert_unused_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && unused_off) |=> $stable(pin_out) && $stable(pin_oe));

    assert_unused_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && unused_off) |=> bus_rdata == '0);

    assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> $stable(bus_rdata));

    if (DIR_MODE == DIRM_BIDIR) begin : g_bidir_chk
        assert_bidir_oe_R9: assert property (@(posedge clk) disable iff (!rst_n)
            pin_oe == '1);
    end
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(
    .W(W), .DIR_MODE(DIR_MODE), .REVERSE(REVERSE), .ADDR_W(ADDR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/gpio_port_ctrl_tb_top.sv
module gpio_port_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [4:0]  addr = '0;
    logic [63:0] wd = '0;
    logic [31:0] pins_a = '0;
    logic [15:0] pins_b = '0;
    logic [7:0]  pins_c = '0;
    logic [31:0] rd_a, out_a, oe_a;
    logic [15:0] rd_b, out_b, oe_b;
    logic [7:0]  rd_c, out_c, oe_c;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [63:0] lat_a = '0, lat_b = '0, lat_c = '0;
    logic [63:0] dir_a = '0, dir_b = 64'hFFFF;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port_ctrl #(.W(32), .DIR_MODE(1), .REVERSE(1'b0), .ADDR_W(5)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wd[31:0]), .bus_rdata(rd_a), .pin_in(pins_a), .pin_out(out_a), .pin_oe(oe_a));

    gpio_port_ctrl #(.W(16), .DIR_MODE(2), .REVERSE(1'b1), .ADDR_W(5)) dut_rev_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wd[15:0]), .bus_rdata(rd_b), .pin_in(pins_b), .pin_out(out_b), .pin_oe(oe_b));

    gpio_port_ctrl #(.W(8), .DIR_MODE(0), .REVERSE(1'b1), .ADDR_W(5)) dut_bidir_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wd[7:0]), .bus_rdata(rd_c), .pin_in(pins_c), .pin_out(out_c), .pin_oe(oe_c));

    function automatic logic [63:0] remap(logic [63:0] v, int w, bit rev);
        logic [63:0] r = '0;
        for (int i = 0; i < w; i++) r[i] = rev ? v[w-1-i] : v[i];
        return r;
    endfunction

    function automatic logic [63:0] msk(int w);
        return (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_write(logic [4:0] a, logic [63:0] d);
        case (a)
            5'h00: begin lat_a = d & msk(32); lat_b = d & msk(16); lat_c = d & msk(8); end
            5'h04: begin lat_a |= d & msk(32); lat_b |= d & msk(16); lat_c |= d & msk(8); end
            5'h08: begin lat_a &= ~d; lat_b &= ~d; lat_c &= ~d; end
            5'h0C: begin dir_a = d & msk(32); dir_b = d & msk(16); end
            default: ;
        endcase
    endtask

    // Called at a negedge: issue the access, return at the following negedge.
    task automatic access_now(logic w, logic [4:0] a, logic [63:0] d);
        sel = 1'b1; wr = w; addr = a; wd = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
        if (w) model_write(a, d);
    endtask

    task automatic bus_write(logic [4:0] a, logic [63:0] d);
        @(negedge clk);
        access_now(1'b1, a, d);
    endtask

    task automatic bus_read(logic [4:0] a);
        @(negedge clk);
        access_now(1'b0, a, '0);
    endtask

    task automatic check_pins(string tag);
        chk({tag, " R2 R10 out A"}, 64'(out_a), remap(lat_a, 32, 1'b0));
        chk({tag, " R2 R10 out B"}, 64'(out_b), remap(lat_b, 16, 1'b1));
        chk({tag, " R2 R10 out C"}, 64'(out_c), remap(lat_c, 8, 1'b1));
        chk({tag, " R7 oe A"},      64'(oe_a),  remap(dir_a, 32, 1'b0));
        chk({tag, " R8 oe B"},      64'(oe_b),  remap(~dir_b & msk(16), 16, 1'b1));
        chk({tag, " R9 oe C"},      64'(oe_c),  64'hFF);
    endtask

    task automatic check_regs(string tag);
        bus_read(5'h04);
        chk({tag, " R5 set rd A"}, 64'(rd_a), lat_a);
        chk({tag, " R5 set rd B"}, 64'(rd_b), lat_b);
        chk({tag, " R5 set rd C"}, 64'(rd_c), lat_c);
        bus_read(5'h0C);
        chk({tag, " R7 dir rd A"}, 64'(rd_a), dir_a);
        chk({tag, " R8 dir rd B"}, 64'(rd_b), dir_b);
        chk({tag, " R9 dir rd C"}, 64'(rd_c), 64'h0);
    endtask

    task automatic check_data_read(string tag);
        repeat (3) @(negedge clk);
        bus_read(5'h00);
        chk({tag, " R6 R10 data A"}, 64'(rd_a), remap(64'(pins_a), 32, 1'b0));
        chk({tag, " R6 R10 data B"}, 64'(rd_b), remap(64'(pins_b), 16, 1'b1));
        chk({tag, " R6 R10 data C"}, 64'(rd_c), remap(64'(pins_c), 8, 1'b1));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] held;
        void'($urandom(32'h1234_5eed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 out A", 64'(out_a), 0);
        chk("R1 oe A",  64'(oe_a),  0);
        chk("R1 out B", 64'(out_b), 0);
        chk("R1 oe B",  64'(oe_b),  0);
        chk("R9 oe C reset", 64'(oe_c), 64'hFF);
        bus_read(5'h0C);
        chk("R1 dir rd A", 64'(rd_a), 0);
        chk("R1 dir rd B", 64'(rd_b), 64'hFFFF);

        // R10 reversal of a single bit
        bus_write(5'h00, 64'h1);
        chk("R10 rev B bit0->pin15", 64'(out_b), 64'h8000);
        chk("R10 rev C bit0->pin7",  64'(out_c), 64'h80);
        chk("R2 fwd A bit0",         64'(out_a), 64'h1);

        // R3/R4 with untouched bits preserved
        bus_write(5'h00, 64'hA5A5_A5A5);
        bus_write(5'h04, 64'h0000_0F0F);
        check_pins("R3 directed");
        bus_write(5'h04, 64'h0);
        check_pins("R3 zero set");
        bus_write(5'h08, 64'h0000_00FF);
        check_pins("R4 directed");
        bus_write(5'h08, 64'h0);
        check_pins("R4 zero clr");

        // R5 set reads latch while pins differ; clear reads zero
        pins_a = 32'h1357_9BDF; pins_b = 16'h2468; pins_c = 8'h3C;
        repeat (3) @(negedge clk);
        check_regs("R5 directed");
        bus_read(5'h08);
        chk("R5 clr rd A", 64'(rd_a), 0);
        chk("R5 clr rd B", 64'(rd_b), 0);

        // R11 unused offsets
        held = lat_a;
        bus_write(5'h10, 64'hFFFF_FFFF);
        bus_write(5'h02, 64'hFFFF_FFFF);
        chk("R11 write ignored A", 64'(out_a), remap(held, 32, 1'b0));
        check_pins("R11 write ignored");
        bus_read(5'h14);
        chk("R11 rd zero A", 64'(rd_a), 0);
        chk("R11 rd zero B", 64'(rd_b), 0);

        // R12 hold after read
        bus_read(5'h04);
        repeat (4) @(negedge clk);
        chk("R12 hold A", 64'(rd_a), lat_a);

        // R6 synchroniser latency
        @(negedge clk);
        held = 64'(pins_a);
        pins_a = ~pins_a;
        access_now(1'b0, 5'h00, '0);
        chk("R6 edge1 old", 64'(rd_a), held);
        access_now(1'b0, 5'h00, '0);
        chk("R6 edge2 old", 64'(rd_a), held);
        access_now(1'b0, 5'h00, '0);
        chk("R6 edge3 new", 64'(rd_a), 64'(pins_a));

        // R7/R8/R9 direction directed
        bus_write(5'h0C, 64'h0000_8001);
        check_pins("R7 R8 R9 dir");
        check_regs("R7 R8 R9 dir");

        // Constrained random mix
        for (int it = 0; it < 300; it++) begin
            int op = $urandom % 6;
            logic [63:0] d = {$urandom, $urandom};
            case (op)
                0: bus_write(5'h00, d);
                1: bus_write(5'h04, d);
                2: bus_write(5'h08, d);
                3: bus_write(5'h0C, d);
                4: bus_write(5'(4 * ($urandom % 4) + 1 + ($urandom % 3)), d);
                default: begin
                    pins_a = $urandom; pins_b = 16'($urandom); pins_c = 8'($urandom);
                    check_data_read("rand");
                end
            endcase
            check_pins("rand");
            if (it % 10 == 0) check_regs("rand");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule